// File: doc/BRIEF.md
# Two-Handed Clock Page Reclaimer

This block reclaims page clusters with the two-handed clock policy. It holds one reference bit and one in-use bit for each of `N_CLUSTERS` clusters in a circular array. Two hands walk the array a fixed distance apart. The front hand clears reference bits. The back hand follows and frees any in-use cluster whose bit is still clear, because nothing has touched that cluster since the front hand passed it.

The block does nothing until a periodic wake tick arrives. On each tick it turns the current shortage of free memory into a step budget. The scan rate is interpolated linearly: `slowscan` when free memory equals `lotsfree`, rising to `fastscan` when free memory is zero. The budget for one wake is a quarter of that rate. The block then takes one step per cycle until the budget is spent or free memory reaches `lotsfree`. A progress counter ends the pass early when the front hand keeps going round without freeing anything. Each freed cluster appears as a one-cycle pulse. The surrounding system updates `free_count` from these pulses. A claim port marks clusters as allocated, and a touch port records memory references.

Top module: `clock_reclaimer`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `scan_count`, `wrap_count` and `freed_valid` become 0 and all clusters become not in use. The back hand goes to index 0. The front hand goes to `hand_spread`, or to `N_CLUSTERS-1` when `hand_spread >= N_CLUSTERS`.
- R2: A cycle with `wake_tick` high latches a step budget. Let hi = max(fastscan, slowscan). Then rate = 0 when lotsfree = 0 or free_count > lotsfree, and otherwise rate = slowscan + floor((hi - slowscan) * (lotsfree - free_count) / lotsfree). The budget is floor(rate / 4). In the next cycle `busy` is 1 and `scan_count` is 0.
- R3: While `busy` is 1 and `wake_tick` is 0, a step is taken in each cycle where `scan_count` < budget and `free_count` < `lotsfree`. In the first cycle where either condition fails, `busy` drops and `scan_count` holds its value.
- R4: In a step, the front hand first clears the reference bit of its cluster. The back hand is then examined. If its cluster is in use and its reference bit is clear after the front hand's action, the cluster becomes not in use. In the next cycle `freed_valid` is 1 for one cycle and `freed_idx` holds the cluster index.
- R5: Each step adds 1 to `scan_count`. Both hands move to the next index, and index `N_CLUSTERS-1` is followed by 0. R6 gives the one exception.
- R6: A progress counter is set to 0 by a tick and by every freed cluster. On a step where the front hand wraps from `N_CLUSTERS-1` to 0, the pass ends (`busy` drops after that step) if the counter is above 2; the back hand does not move on that step. Otherwise the counter goes up by 1.
- R7: `wrap_count` goes up by 1 each time the front hand wraps. It is cleared only by reset.
- R8: `touch_valid` with `touch_idx` sets the reference bit of that cluster if it is in use. A touch on a cluster that is not in use has no effect.
- R9: `claim_valid` with `claim_idx` marks that cluster in use with its reference bit clear.
- R10: A touch or claim on a cluster in the same cycle as a scanner step overrides the scanner for that cluster. The front hand's clear does not take effect, and the back hand does not free the cluster.
- R11: A tick during a pass restarts it. No step is taken in the tick cycle, the budget is recomputed, and the progress counter and `scan_count` restart from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_tick | input | 1 | Periodic wake pulse (four per second in the system) |
| claim_valid | input | 1 | Mark a cluster as allocated |
| claim_idx | input | IDX_W | Cluster index for a claim |
| touch_valid | input | 1 | Memory reference to a cluster |
| touch_idx | input | IDX_W | Cluster index for a reference |
| free_count | input | CNT_W | Current number of free clusters |
| lotsfree | input | CNT_W | Free level at which scanning stops |
| slowscan | input | CNT_W | Scan rate at free = lotsfree |
| fastscan | input | CNT_W | Scan rate at free = 0 |
| hand_spread | input | CNT_W | Distance between the hands, sampled during reset |
| freed_valid | output | 1 | One-cycle pulse per freed cluster |
| freed_idx | output | IDX_W | Index of the freed cluster |
| scan_count | output | CNT_W | Steps taken in the current or last pass |
| wrap_count | output | CNT_W | Total number of front-hand wraps |
| busy | output | 1 | A pass is in progress |

## Verification
The hardest state to reach is the abandoned pass. It needs four front-hand wraps in a row with no freed cluster and a budget large enough not to end the pass first. Random traffic almost never produces this, because any in-use cluster with a clear bit breaks the run. The bench reaches it on purpose with an empty array, a zero free count and a high `fastscan`, then checks the exact step count at which the pass stops. Same-cycle conflicts between a touch and the back hand are forced by timing a touch into the first step after a tick. Long random runs compare every cycle against a bench model.

// File: rtl/reclaim_pkg.sv
package reclaim_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;

    // Per-cycle decisions of the hand controller.
    typedef struct packed {
        logic stepping;   // a scan step happens this cycle
        logic drop;       // back hand frees its cluster
        logic fwrap;      // front hand leaves the last index
        logic quit;       // pass abandoned for lack of progress
    } step_flags_t;

    // Steps granted to one wake: a quarter of the interpolated scan rate.
    function automatic logic [31:0] pass_budget(
        input logic [31:0] free_n,
        input logic [31:0] lots,
        input logic [31:0] slow,
        input logic [31:0] fast
    );
        logic [31:0] ceil_r;
        logic [31:0] span;
        logic [31:0] deficit;
        logic [63:0] prod;
        logic [63:0] quo;
        logic [31:0] rate;
        ceil_r  = (fast > slow) ? fast : slow;
        span    = ceil_r - slow;
        deficit = lots - free_n;
        prod    = {32'd0, span} * {32'd0, deficit};
        quo     = (lots == 32'd0) ? 64'd0 : prod / {32'd0, lots};
        rate    = slow + quo[31:0];
        if (lots == 32'd0 || free_n > lots) begin
            rate = 32'd0;
        end
        return rate >> 2;
    endfunction

    // Starting position of the front hand, clamped into the array.
    function automatic logic [31:0] front_home(
        input logic [31:0] spread,
        input logic [31:0] n
    );
        return (spread >= n) ? (n - 32'd1) : spread;
    endfunction

endpackage

// File: rtl/reclaim_budget.sv
module reclaim_budget
    import reclaim_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [CW-1:0] free_count,
    input  logic [CW-1:0] lotsfree,
    input  logic [CW-1:0] slowscan,
    input  logic [CW-1:0] fastscan,
    output logic [CW-1:0] budget,
    output logic          below_lots
);

    always_comb begin
        budget     = CW'(pass_budget(32'(free_count), 32'(lotsfree),
                                     32'(slowscan), 32'(fastscan)));
        below_lots = (free_count < lotsfree);
    end

endmodule

// File: rtl/reclaim_cluster_array.sv
module reclaim_cluster_array #(
    parameter  int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          claim_valid,
    input  logic [IW-1:0] claim_idx,
    input  logic          touch_valid,
    input  logic [IW-1:0] touch_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    input  logic          drop_en,
    input  logic [IW-1:0] drop_idx,
    output logic [N-1:0]  ref_bits,
    output logic [N-1:0]  use_bits
);

    for (genvar c = 0; c < N; c++) begin : g_cl
        logic ref_q;
        logic use_q;
        logic claim_hit;
        logic touch_hit;

        assign claim_hit = claim_valid && (claim_idx == IW'(c));
        assign touch_hit = touch_valid && (touch_idx == IW'(c)) && use_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ref_q <= 1'b0;
                use_q <= 1'b0;
            end else if (claim_hit) begin
                use_q <= 1'b1;
                ref_q <= 1'b0;
            end else if (touch_hit) begin
                ref_q <= 1'b1;
            end else begin
                if (clr_en && clr_idx == IW'(c)) begin
                    ref_q <= 1'b0;
                end
                if (drop_en && drop_idx == IW'(c)) begin
                    use_q <= 1'b0;
                    ref_q <= 1'b0;
                end
            end
        end

        assign ref_bits[c] = ref_q;
        assign use_bits[c] = use_q;
    end

endmodule

// File: rtl/reclaim_hand_ctrl.sv
module reclaim_hand_ctrl
    import reclaim_pkg::*;
#(
    parameter  int N  = 16,
    parameter  int CW = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wake_tick,
    input  logic [CW-1:0] budget,
    input  logic          below_lots,
    input  logic [N-1:0]  ref_bits,
    input  logic [N-1:0]  use_bits,
    input  logic          touch_valid,
    input  logic [IW-1:0] touch_idx,
    input  logic          claim_valid,
    input  logic [IW-1:0] claim_idx,
    input  logic [CW-1:0] hand_spread,
    output logic          clr_en,
    output logic [IW-1:0] clr_idx,
    output logic          drop_en,
    output logic [IW-1:0] drop_idx,
    output logic          freed_valid,
    output logic [IW-1:0] freed_idx,
    output logic [CW-1:0] scan_count,
    output logic [CW-1:0] wrap_count,
    output logic          busy
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    phase_e      phase_q;
    logic [IW-1:0] fh_q, bh_q, bh_next, fh_home;
    logic [CW-1:0] scanned_q, target_q, wraps_q;
    logic [1:0]    prog_q, prog_base;
    step_flags_t   sf;
    logic          hit_back, ref_at_back;

    always_comb begin
        fh_home     = IW'(front_home(32'(hand_spread), 32'(N)));
        hit_back    = (touch_valid && touch_idx == bh_q) ||
                      (claim_valid && claim_idx == bh_q);
        // front hand acts first: a shared cluster is seen already cleared
        ref_at_back = (fh_q == bh_q) ? 1'b0 : ref_bits[bh_q];
        sf.stepping = (phase_q == PH_SCAN) && !wake_tick &&
                      (scanned_q < target_q) && below_lots;
        sf.drop     = sf.stepping && use_bits[bh_q] && !ref_at_back && !hit_back;
        sf.fwrap    = sf.stepping && (fh_q == LAST);
        prog_base   = sf.drop ? 2'd0 : prog_q;
        sf.quit     = sf.fwrap && (prog_base > 2'd2);
        bh_next     = (bh_q == LAST) ? '0 : bh_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_IDLE;
            fh_q        <= fh_home;
            bh_q        <= '0;
            scanned_q   <= '0;
            target_q    <= '0;
            wraps_q     <= '0;
            prog_q      <= '0;
            freed_valid <= 1'b0;
            freed_idx   <= '0;
        end else begin
            freed_valid <= sf.drop;
            freed_idx   <= bh_q;
            if (wake_tick) begin
                target_q  <= budget;
                scanned_q <= '0;
                prog_q    <= '0;
                phase_q   <= PH_SCAN;
            end else if (phase_q == PH_SCAN) begin
                if (!sf.stepping) begin
                    phase_q <= PH_IDLE;
                end else begin
                    scanned_q <= scanned_q + 1'b1;
                    if (sf.fwrap) begin
                        fh_q    <= '0;
                        wraps_q <= wraps_q + 1'b1;
                        if (sf.quit) begin
                            phase_q <= PH_IDLE;
                            prog_q  <= prog_base;
                        end else begin
                            prog_q <= prog_base + 2'd1;
                            bh_q   <= bh_next;
                        end
                    end else begin
                        fh_q   <= fh_q + 1'b1;
                        bh_q   <= bh_next;
                        prog_q <= prog_base;
                    end
                end
            end
        end
    end

    assign clr_en     = sf.stepping;
    assign clr_idx    = fh_q;
    assign drop_en    = sf.drop;
    assign drop_idx   = bh_q;
    assign scan_count = scanned_q;
    assign wrap_count = wraps_q;
    assign busy       = (phase_q == PH_SCAN);

endmodule

// File: rtl/clock_reclaimer.sv
module clock_reclaimer #(
    parameter  int N_CLUSTERS = 16,
    parameter  int CNT_W      = 16,
    localparam int IDX_W      = $clog2(N_CLUSTERS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_tick,
    input  logic             claim_valid,
    input  logic [IDX_W-1:0] claim_idx,
    input  logic             touch_valid,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [CNT_W-1:0] free_count,
    input  logic [CNT_W-1:0] lotsfree,
    input  logic [CNT_W-1:0] slowscan,
    input  logic [CNT_W-1:0] fastscan,
    input  logic [CNT_W-1:0] hand_spread,
    output logic             freed_valid,
    output logic [IDX_W-1:0] freed_idx,
    output logic [CNT_W-1:0] scan_count,
    output logic [CNT_W-1:0] wrap_count,
    output logic             busy
);

    logic [CNT_W-1:0]      budget;
    logic                  below_lots;
    logic [N_CLUSTERS-1:0] ref_bits, use_bits;
    logic                  clr_en, drop_en;
    logic [IDX_W-1:0]      clr_idx, drop_idx;

    reclaim_budget #(.CW(CNT_W)) u_budget (
        .free_count (free_count),
        .lotsfree   (lotsfree),
        .slowscan   (slowscan),
        .fastscan   (fastscan),
        .budget     (budget),
        .below_lots (below_lots)
    );

    reclaim_cluster_array #(.N(N_CLUSTERS)) u_array (
        .clk         (clk),
        .rst         (rst),
        .claim_valid (claim_valid),
        .claim_idx   (claim_idx),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .clr_en      (clr_en),
        .clr_idx     (clr_idx),
        .drop_en     (drop_en),
        .drop_idx    (drop_idx),
        .ref_bits    (ref_bits),
        .use_bits    (use_bits)
    );

    reclaim_hand_ctrl #(.N(N_CLUSTERS), .CW(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wake_tick   (wake_tick),
        .budget      (budget),
        .below_lots  (below_lots),
        .ref_bits    (ref_bits),
        .use_bits    (use_bits),
        .touch_valid (touch_valid),
        .touch_idx   (touch_idx),
        .claim_valid (claim_valid),
        .claim_idx   (claim_idx),
        .hand_spread (hand_spread),
        .clr_en      (clr_en),
        .clr_idx     (clr_idx),
        .drop_en     (drop_en),
        .drop_idx    (drop_idx),
        .freed_valid (freed_valid),
        .freed_idx   (freed_idx),
        .scan_count  (scan_count),
        .wrap_count  (wrap_count),
        .busy        (busy)
    );

endmodule

// File: rtl/reclaim_checker.sv
module reclaim_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          wake_tick,
    input logic [CW-1:0] free_count,
    input logic [CW-1:0] lotsfree,
    input logic          freed_valid,
    input logic [CW-1:0] scan_count,
    input logic [CW-1:0] wrap_count,
    input logic          busy
);

    // R3: free memory at or above the threshold ends the pass at once
    a_r3_halt_at_lots: assert property (@(posedge clk) disable iff (rst)
        (busy && !wake_tick && free_count >= lotsfree) |=>
        (!busy && scan_count == $past(scan_count)));

    // R11 / R2: a tick always opens a fresh pass
    a_r11_tick_restarts: assert property (@(posedge clk) disable iff (rst)
        wake_tick |=> (busy && scan_count == '0));

    // R7: the wrap counter never jumps by more than one
    a_r7_wrap_by_one: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wrap_count == $past(wrap_count) ||
                  wrap_count == $past(wrap_count) + CW'(1)));

    // R4: clusters are only freed by a running pass
    a_r4_free_needs_busy: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !freed_valid);

    // R5: the step count grows by at most one per cycle inside a pass
    a_r5_scan_by_one: assert property (@(posedge clk) disable iff (rst)
        (busy && !wake_tick) |=> (scan_count == $past(scan_count) ||
                                  scan_count == $past(scan_count) + CW'(1)));

    // R2: an idle scanner stays idle and keeps its count until a tick
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wake_tick) |=> (!busy && $stable(scan_count)));

endmodule

bind clock_reclaimer reclaim_checker #(.CW(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wake_tick   (wake_tick),
    .free_count  (free_count),
    .lotsfree    (lotsfree),
    .freed_valid (freed_valid),
    .scan_count  (scan_count),
    .wrap_count  (wrap_count),
    .busy        (busy)
);

// File: tb/clock_reclaimer_tb.sv
module clock_reclaimer_tb_top;

    localparam int N  = 16;
    localparam int CW = 16;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wake_tick = 1'b0;
    logic          claim_valid = 1'b0;
    logic [IW-1:0] claim_idx = '0;
    logic          touch_valid = 1'b0;
    logic [IW-1:0] touch_idx = '0;
    logic [CW-1:0] free_count = '0;
    logic [CW-1:0] lotsfree = '0;
    logic [CW-1:0] slowscan = '0;
    logic [CW-1:0] fastscan = '0;
    logic [CW-1:0] hand_spread = '0;
    logic          freed_valid;
    logic [IW-1:0] freed_idx;
    logic [CW-1:0] scan_count;
    logic [CW-1:0] wrap_count;
    logic          busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    clock_reclaimer #(.N_CLUSTERS(N), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .wake_tick(wake_tick),
        .claim_valid(claim_valid), .claim_idx(claim_idx),
        .touch_valid(touch_valid), .touch_idx(touch_idx),
        .free_count(free_count), .lotsfree(lotsfree),
        .slowscan(slowscan), .fastscan(fastscan), .hand_spread(hand_spread),
        .freed_valid(freed_valid), .freed_idx(freed_idx),
        .scan_count(scan_count), .wrap_count(wrap_count), .busy(busy)
    );

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Budget from the interpolation rule of R2.
    function automatic int exp_budget(int fr, int lo, int sl, int fa);
        int     hi;
        longint r;
        if (lo == 0 || fr > lo) return 0;
        hi = (fa < sl) ? sl : fa;
        r  = sl + (longint'(hi - sl) * longint'(lo - fr)) / lo;
        return int'(r / 4);
    endfunction

    // ---------------- behavioural model ----------------
    bit m_ref [N];
    bit m_use [N];
    int m_fh, m_bh, m_scan, m_tgt, m_prog, m_wrap, m_fidx;
    bit m_act, m_fv;

    always @(posedge clk) begin
        if (rst) begin
            m_fh = (int'(hand_spread) >= N) ? N - 1 : int'(hand_spread);
            m_bh = 0; m_scan = 0; m_tgt = 0; m_prog = 0; m_wrap = 0;
            m_act = 0; m_fv = 0; m_fidx = 0;
            for (int i = 0; i < N; i++) begin m_ref[i] = 0; m_use[i] = 0; end
        end else begin
            bit stp, hitb, touchf;
            int f, b;
            f = m_fh; b = m_bh; m_fv = 0;
            stp = !wake_tick && m_act && (m_scan < m_tgt) && (free_count < lotsfree);
            if (stp) begin
                hitb   = (touch_valid && int'(touch_idx) == b) ||
                         (claim_valid && int'(claim_idx) == b);
                touchf = touch_valid && int'(touch_idx) == f && m_use[f];
                if (!touchf) m_ref[f] = 0;                    // R4 front first
                if (m_use[b] && !m_ref[b] && !hitb) begin     // R4 / R10
                    m_use[b] = 0; m_fv = 1; m_fidx = b; m_prog = 0;
                end
                m_scan = (m_scan + 1) & 16'hFFFF;
                if (f == N - 1) begin
                    m_fh = 0; m_wrap = (m_wrap + 1) & 16'hFFFF;
                    if (m_prog > 2) m_act = 0;                // R6
                    else begin m_prog++; m_bh = (b + 1) % N; end
                end else begin
                    m_fh = f + 1; m_bh = (b + 1) % N;
                end
            end else if (wake_tick) begin
                m_tgt  = exp_budget(free_count, lotsfree, slowscan, fastscan);
                m_scan = 0; m_prog = 0; m_act = 1;
            end else if (m_act) begin
                m_act = 0;
            end
            if (touch_valid && m_use[touch_idx]) m_ref[touch_idx] = 1;   // R8
            if (claim_valid) begin m_use[claim_idx] = 1; m_ref[claim_idx] = 0; end // R9
        end
    end

    // Per-cycle comparison against the model.
    int mon_freed = 0;
    int mon_last  = -1;
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3", "busy", busy, m_act);
            chk("R2 R5", "scan_count", scan_count, m_scan);
            chk("R7", "wrap_count", wrap_count, m_wrap);
            chk("R4 R8 R9 R10", "freed_valid", freed_valid, m_fv);
            if (m_fv) chk("R4 R5", "freed_idx", freed_idx, m_fidx);
            if (freed_valid) begin mon_freed++; mon_last = freed_idx; end
        end
    end

    task automatic do_reset(input int spread);
        @(negedge clk);
        rst = 1; hand_spread = CW'(spread);
        wake_tick = 0; claim_valid = 0; touch_valid = 0;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic set_rate(input int fr, input int lo, input int sl, input int fa);
        free_count = CW'(fr); lotsfree = CW'(lo); slowscan = CW'(sl); fastscan = CW'(fa);
    endtask

    task automatic tick_once();
        @(negedge clk); wake_tick = 1;
        @(negedge clk); wake_tick = 0;
    endtask

    initial begin
        int base;
        void'($urandom(32'd4242));

        // R1: reset state
        do_reset(4);
        @(negedge clk);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "scan_count after reset", scan_count, 0);
        chk("R1", "wrap_count after reset", wrap_count, 0);
        chk("R1", "freed_valid after reset", freed_valid, 0);

        // R6: empty array, large budget -> abandon after the fourth wrap
        set_rate(0, 64, 8, 400);
        tick_once();
        repeat (110) @(negedge clk);
        chk("R6", "scan_count at abandon", scan_count, 60);
        chk("R7", "wraps at abandon", wrap_count, 4);
        chk("R6", "busy after abandon", busy, 0);

        // R2: budget from interpolation, (8 + 192*32/64)/4 = 26
        set_rate(32, 64, 8, 200);
        tick_once();
        repeat (40) @(negedge clk);
        chk("R2", "budget steps", scan_count, exp_budget(32, 64, 8, 200));
        chk("R2", "budget literal", scan_count, 26);

        // R3: free at threshold -> no step
        set_rate(64, 64, 8, 200);
        tick_once();
        repeat (3) @(negedge clk);
        chk("R3", "busy at lotsfree", busy, 0);
        chk("R3", "scan at lotsfree", scan_count, 0);

        // R11: second tick mid-pass restarts
        set_rate(0, 64, 8, 400);
        tick_once();
        repeat (5) @(negedge clk);
        tick_once();
        chk("R11", "scan after retick", scan_count, 0);
        chk("R11", "busy after retick", busy, 1);
        repeat (120) @(negedge clk);

        // R1 clamp + R4: spread beyond array, all clusters in use and referenced
        do_reset(20);
        for (int i = 0; i < N; i++) begin
            @(negedge clk); claim_valid = 1; claim_idx = IW'(i);
        end
        @(negedge clk); claim_valid = 0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk); touch_valid = 1; touch_idx = IW'(i);
        end
        @(negedge clk); touch_valid = 0;
        base = mon_freed;
        set_rate(0, 64, 0, 64);
        tick_once();
        repeat (25) @(negedge clk);
        chk("R1 R4", "frees with clamped spread", mon_freed - base, 1);
        chk("R1 R4", "first freed index", mon_last, 15);

        // R10: touch on back-hand cluster in the step cycle blocks the free
        base = mon_freed;
        set_rate(0, 64, 0, 4);
        @(negedge clk); wake_tick = 1;
        @(negedge clk); wake_tick = 0; touch_valid = 1; touch_idx = '0;
        @(negedge clk); touch_valid = 0;
        repeat (4) @(negedge clk);
        chk("R10", "no free under same-cycle touch", mon_freed - base, 0);
        // next step: front clears 0, back frees 1 (claimed, R9)
        tick_once();
        repeat (4) @(negedge clk);
        chk("R9 R10", "frees in following pass", mon_freed - base, 1);
        chk("R9", "freed index following pass", mon_last, 1);

        // Random traffic against the model (R8 ignored touches included)
        do_reset(int'($urandom_range(0, 20)));
        for (int cyc = 0; cyc < 4000; cyc++) begin
            int lo;
            @(negedge clk);
            claim_valid = ($urandom_range(0, 7) == 0);
            claim_idx   = IW'($urandom_range(0, N - 1));
            touch_valid = ($urandom_range(0, 3) == 0);
            touch_idx   = IW'($urandom_range(0, N - 1));
            wake_tick   = ($urandom_range(0, 59) == 0);
            if (wake_tick || $urandom_range(0, 49) == 0) begin
                lo = int'($urandom_range(32, 95));
                set_rate(int'($urandom_range(0, lo + 10)), lo,
                         int'($urandom_range(0, 39)), int'($urandom_range(0, 399)));
            end
        end
        @(negedge clk);
        wake_tick = 0; claim_valid = 0; touch_valid = 0;
        repeat (5) @(negedge clk);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule